// File: doc/BRIEF.md
# MDIO Read Master with Scan

This block is the master side of the two-wire PHY management bus. It produces the management clock by dividing the system clock and shifts out Clause 22 read frames. It captures the 16-bit register value the PHY returns. Control arrives as plain inputs: a clock-select code, a preamble-suppress bit, a soft-reset bit, a PHY address, a register address, a one-cycle read command and a level-sensitive scan command.

A read command runs exactly one frame. Holding the scan command runs frames back to back on the same PHY and register until the command is dropped. The current frame then finishes and the block goes idle. Three status outputs report busy, scanning and result-not-valid. The last completed result is held on `rd_data`.

Top module: `mdio_rd_master`

## Requirements
- R1: The management clock period equals the divide ratio picked by `cfg_clk_sel`, in system clocks, half high and half low. The code-to-ratio table is 0→4, 1→4, 2→6, 3→8, 4→10, 5→14, 6→20, 7→28. The ratio is fixed at the start of each command.
- R2: With `cfg_no_pre` low, each frame begins with 32 driven 1 bits. With it high, the frame begins directly at the start bits.
- R3: After the preamble, the driven bits are 0,1 (start), 1,0 (read opcode), the 5-bit PHY address MSB first, and the 5-bit register address MSB first. The bus is then released (`mdio_oe` low) for two turnaround bits and the 16 data bits.
- R4: `mdio_out` and `mdio_oe` change only at a falling management-clock edge. The 16 data bits are sampled at rising edges, MSB first. The completed word appears on `rd_data`.
- R5: A read command with the block idle runs exactly one frame. `stat_busy` stays high for (bits × ratio) system clocks, where bits is 64 with preamble and 32 without.
- R6: `stat_not_valid` is 1 after reset and from the accepted command until the first frame completes. It is 0 once that frame completes.
- R7: While `cmd_scan` is held, frames repeat with no idle gap. `stat_scanning` and `stat_busy` stay high, and `rd_data` takes each new result. After `cmd_scan` drops, the frame in progress completes and the block goes idle.
- R8: A command that arrives while busy is ignored, including any new addresses. A command with PHY address 0 is ignored.
- R9: When idle, the management clock is low and the bus is released.
- R10: `cfg_soft_rst` aborts any frame. One cycle later the block is idle with the clock low, `stat_not_valid` is 1 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_sel | input | 3 | Divide-ratio code |
| cfg_no_pre | input | 1 | Suppress preamble |
| cfg_soft_rst | input | 1 | Synchronous return to idle |
| cmd_read | input | 1 | One-cycle single-read request |
| cmd_scan | input | 1 | Level: repeat reads while high |
| phy_addr | input | 5 | Target PHY address (0 reserved) |
| reg_addr | input | 5 | Target register address |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | Output enable for mdio_out |
| mdio_in | input | 1 | Serial data from the bus |
| stat_busy | output | 1 | A frame is in progress |
| stat_scanning | output | 1 | Scan mode active |
| stat_not_valid | output | 1 | Result not yet valid |
| rd_data | output | 16 | Last captured register value |

## Verification
A wrong bit index shows on the bus within one management-clock period. The PHY model then decodes the wrong address, misses the start bits or sees the bus driven in turnaround, and the frame's header check flags it. A wrong capture edge or shift order leaves a corrupted `rd_data` at the end of that same frame. A divider fault shows as a wrong measured period at the next rising edge and a wrong busy length. A faulty scan or ignore path shows as a wrong count of frames seen by the model.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CNT_W   = 4;
    localparam int RATIO_W = 5;

    function automatic logic [RATIO_W-1:0] div_ratio(input logic [2:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'd0, 3'd1: r = 5'd4;
            3'd2:       r = 5'd6;
            3'd3:       r = 5'd8;
            3'd4:       r = 5'd10;
            3'd5:       r = 5'd14;
            3'd6:       r = 5'd20;
            default:    r = 5'd28;
        endcase
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] half_minus1(input logic [2:0] code);
        logic [RATIO_W-1:0] r;
        r = div_ratio(code);
        return r[RATIO_W-1:1] - 1'b1;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] half_m1,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d    = q;
        rise = 1'b0;
        fall = 1'b0;
        if (clr || !run) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (q.cnt == half_m1) begin
            d.cnt = '0;
            d.mdc = !q.mdc;
            rise  = !q.mdc;
            fall  = q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.mdc;

    // R1
    half_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && rise) |=> (mdc && q.cnt == '0));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_clk_sel,
    input  logic              cfg_no_pre,
    input  logic              cfg_soft_rst,
    input  logic              cmd_read,
    input  logic              cmd_scan,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_in,
    output logic              active,
    output logic              scanning,
    output logic              not_valid,
    output logic [CNT_W-1:0]  half_m1,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int HDR_LEN    = 4 + 2 * ADDR_W;
    localparam int FRAME_LEN  = PRE_LEN + HDR_LEN + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int DRIVE_END  = PRE_LEN + HDR_LEN;
    localparam int DATA_START = DRIVE_END + 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
    localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);

    typedef struct packed {
        logic              active;
        logic              scan;
        logic              nvalid;
        logic              no_pre;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] rga;
        logic [CNT_W-1:0]  half_m1;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t q, d;
    logic start_ok;
    int   k;

    assign start_ok = (cmd_read || cmd_scan) && (phy_addr != '0);

    always_comb begin
        d = q;
        if (cfg_soft_rst) begin
            d.active = 1'b0;
            d.scan   = 1'b0;
            d.nvalid = 1'b1;
            d.idx    = '0;
            d.rdata  = '0;
        end else if (!q.active) begin
            if (start_ok) begin
                d.active  = 1'b1;
                d.scan    = cmd_scan;
                d.nvalid  = 1'b1;
                d.no_pre  = cfg_no_pre;
                d.idx     = cfg_no_pre ? PRE_IDX : '0;
                d.phy     = phy_addr;
                d.rga     = reg_addr;
                d.half_m1 = half_minus1(cfg_clk_sel);
            end
        end else begin
            if (rise && int'(q.idx) >= DATA_START)
                d.shreg = {q.shreg[DATA_W-2:0], mdio_in};
            if (fall) begin
                if (q.idx == LAST_IDX) begin
                    d.rdata  = q.shreg;
                    d.nvalid = 1'b0;
                    if (q.scan && cmd_scan) begin
                        d.idx = q.no_pre ? PRE_IDX : '0;
                    end else begin
                        d.active = 1'b0;
                        d.scan   = 1'b0;
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.nvalid <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        k        = int'(q.idx) - PRE_LEN;
        mdio_out = 1'b0;
        mdio_oe  = q.active && (int'(q.idx) < DRIVE_END);
        if (q.active) begin
            if (k < 0)                 mdio_out = 1'b1;
            else if (k == 1 || k == 2) mdio_out = 1'b1;
            else if (k >= 4 && k < 4 + ADDR_W)
                mdio_out = q.phy[ADDR_W + 3 - k];
            else if (k >= 4 + ADDR_W && k < HDR_LEN)
                mdio_out = q.rga[HDR_LEN - 1 - k];
        end
    end

    assign active    = q.active;
    assign scanning  = q.scan;
    assign not_valid = q.nvalid;
    assign half_m1   = q.half_m1;
    assign rd_data   = q.rdata;

    // R3
    released_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && rise && int'(q.idx) >= DATA_START) |-> !mdio_oe);
    // R6
    valid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && fall && q.idx == LAST_IDX && !cfg_soft_rst) |=> !not_valid);
endmodule

// File: rtl/mdio_rd_master.sv
module mdio_rd_master
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_clk_sel,
    input  logic              cfg_no_pre,
    input  logic              cfg_soft_rst,
    input  logic              cmd_read,
    input  logic              cmd_scan,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in,
    output logic              stat_busy,
    output logic              stat_scanning,
    output logic              stat_not_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic             run, rise_s, fall_s;
    logic [CNT_W-1:0] half_m1;

    mdio_clkgen u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clr     (cfg_soft_rst),
        .half_m1 (half_m1),
        .mdc     (mdc),
        .rise    (rise_s),
        .fall    (fall_s)
    );

    mdio_seq #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_clk_sel  (cfg_clk_sel),
        .cfg_no_pre   (cfg_no_pre),
        .cfg_soft_rst (cfg_soft_rst),
        .cmd_read     (cmd_read),
        .cmd_scan     (cmd_scan),
        .phy_addr     (phy_addr),
        .reg_addr     (reg_addr),
        .rise         (rise_s),
        .fall         (fall_s),
        .mdio_in      (mdio_in),
        .active       (run),
        .scanning     (stat_scanning),
        .not_valid    (stat_not_valid),
        .half_m1      (half_m1),
        .rd_data      (rd_data),
        .mdio_out     (mdio_out),
        .mdio_oe      (mdio_oe)
    );

    assign stat_busy = run;

    // R9
    idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_busy |-> !mdc);
    // R7
    scan_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_scanning |-> stat_busy);
    // R10
    soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_soft_rst |=> (!stat_busy && !mdc && stat_not_valid));
    // R4
    drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_busy && $past(stat_busy) &&
         (mdio_out != $past(mdio_out) || mdio_oe != $past(mdio_oe))) |-> $fell(mdc));
    // R4
    capture_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data) && !$past(cfg_soft_rst)) |-> $fell(mdc));
endmodule

// File: tb/mdio_rd_master_tb_top.sv
module mdio_rd_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_clk_sel = '0;
    logic        cfg_no_pre = 1'b0;
    logic        cfg_soft_rst = 1'b0;
    logic        cmd_read = 1'b0;
    logic        cmd_scan = 1'b0;
    logic [4:0]  phy_addr = 5'd1;
    logic [4:0]  reg_addr = '0;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b0;
    logic        stat_busy, stat_scanning, stat_not_valid;
    logic [15:0] rd_data;

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    mdio_rd_master dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_clk_sel(cfg_clk_sel), .cfg_no_pre(cfg_no_pre),
        .cfg_soft_rst(cfg_soft_rst), .cmd_read(cmd_read), .cmd_scan(cmd_scan),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in), .stat_busy(stat_busy),
        .stat_scanning(stat_scanning), .stat_not_valid(stat_not_valid), .rd_data(rd_data)
    );

    // PHY model state
    int          k = -1;
    int          pre_run = 0;
    int          last_pre = -1;
    int          frames = 0;
    int          period = 0;
    int          last_rise = 0;
    logic        ta_bad = 1'b0;
    logic [13:0] hdr = '0;
    logic [15:0] word = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge mdc or negedge stat_busy) begin
        if (!stat_busy) begin
            k       = -1;
            pre_run = 0;
        end else begin
            if (k > 0) period = cyc - last_rise;
            last_rise = cyc;
            if (k < 0) begin
                if (mdio_oe && mdio_out) pre_run++;
                else if (mdio_oe && !mdio_out) begin
                    last_pre = pre_run;
                    pre_run  = 0;
                    hdr      = {hdr[12:0], 1'b0};
                    k        = 1;
                end
            end else if (k < 14) begin
                if (!mdio_oe) ta_bad = 1'b1;
                hdr = {hdr[12:0], mdio_out};
                k++;
                if (k == 14) word = {hdr[9:5], hdr[4:0], 6'(frames)};
            end else begin
                if (mdio_oe) ta_bad = 1'b1;
                k++;
                if (k == 32) begin
                    k = -1;
                    frames++;
                end
            end
        end
    end

    always @(negedge mdc) begin
        if (k >= 16 && k <= 31) mdio_in <= word[31-k];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int sel);
        case (sel)
            0, 1: return 4;
            2: return 6;
            3: return 8;
            4: return 10;
            5: return 14;
            6: return 20;
            default: return 28;
        endcase
    endfunction

    task automatic wait_idle(output int bc);
        bc = 0;
        while (stat_busy) begin
            bc++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_read();
        @(negedge clk) cmd_read = 1'b1;
        @(negedge clk) cmd_read = 1'b0;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int bc, f0, n, bits;
        logic [4:0] ph, rg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 R6 reset state
        chk("R9 idle mdc", {31'd0, mdc}, 0);
        chk("R9 idle oe", {31'd0, mdio_oe}, 0);
        chk("R6 not_valid after reset", {31'd0, stat_not_valid}, 1);
        chk("R10 rd_data reset", {16'd0, rd_data}, 0);
        chk("R7 scanning reset", {31'd0, stat_scanning}, 0);

        // sweep of every clock code with and without preamble
        for (int sel = 0; sel < 8; sel++) begin
            for (int np = 0; np < 2; np++) begin
                ph = 5'(sel + 1 + np * 16);
                rg = 5'((sel * 3 + np * 17) & 31);
                cfg_clk_sel = 3'(sel);
                cfg_no_pre  = np[0];
                phy_addr = ph;
                reg_addr = rg;
                f0 = frames;
                n = ratio_of(sel);
                bits = np ? 32 : 64;
                ta_bad = 1'b0;
                pulse_read();
                chk("R6 not_valid during read", {31'd0, stat_not_valid}, 1);
                wait_idle(bc);
                chk("R5 busy length", bc, bits * n);
                chk("R5 one frame", frames, f0 + 1);
                chk("R1 mdc period", period, n);
                chk("R2 preamble length", last_pre, np ? 0 : 32);
                chk("R3 start and opcode", {28'd0, hdr[13:10]}, 4'b0110);
                chk("R3 phy field", {27'd0, hdr[9:5]}, {27'd0, ph});
                chk("R3 reg field", {27'd0, hdr[4:0]}, {27'd0, rg});
                chk("R3 released in turnaround/data", {31'd0, ta_bad}, 0);
                chk("R4 read data", {16'd0, rd_data}, {16'd0, ph, rg, 6'(f0)});
                chk("R6 not_valid after read", {31'd0, stat_not_valid}, 0);
                chk("R9 idle after read", {30'd0, mdc, mdio_oe}, 0);
            end
        end

        // R7 scan mode
        cfg_clk_sel = 3'd0;
        cfg_no_pre  = 1'b1;
        phy_addr = 5'd5;
        reg_addr = 5'd9;
        f0 = frames;
        bc = 0;
        @(negedge clk) cmd_scan = 1'b1;
        @(negedge clk);
        while (frames < f0 + 3) begin
            if (!stat_busy) bc++;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk("R7 no gap between scan frames", bc, 0);
        chk("R7 scanning flag", {31'd0, stat_scanning}, 1);
        chk("R7 not_valid cleared in scan", {31'd0, stat_not_valid}, 0);
        chk("R7 result updates per frame", {16'd0, rd_data}, {16'd0, 5'd5, 5'd9, 6'(f0 + 2)});
        cmd_scan = 1'b0;
        wait_idle(bc);
        chk("R7 ends after current frame", frames, f0 + 4);
        chk("R7 last scan result", {16'd0, rd_data}, {16'd0, 5'd5, 5'd9, 6'(f0 + 3)});
        chk("R7 scanning cleared", {31'd0, stat_scanning}, 0);

        // R8 command while busy ignored
        cfg_clk_sel = 3'd3;
        cfg_no_pre  = 1'b0;
        phy_addr = 5'd3;
        reg_addr = 5'd4;
        f0 = frames;
        pulse_read();
        repeat (100) @(negedge clk);
        phy_addr = 5'd7;
        reg_addr = 5'd1;
        cmd_read = 1'b1;
        cmd_scan = 1'b1;
        @(negedge clk);
        cmd_read = 1'b0;
        cmd_scan = 1'b0;
        wait_idle(bc);
        repeat (50) @(negedge clk);
        chk("R8 busy command ignored frames", frames, f0 + 1);
        chk("R8 busy command kept address", {16'd0, rd_data}, {16'd0, 5'd3, 5'd4, 6'(f0)});
        chk("R8 stays idle", {31'd0, stat_busy}, 0);

        // R8 phy address 0 ignored
        phy_addr = 5'd0;
        pulse_read();
        chk("R8 phy 0 ignored busy", {31'd0, stat_busy}, 0);
        chk("R8 phy 0 ignored not_valid", {31'd0, stat_not_valid}, 0);

        // R10 soft reset mid-frame
        cfg_clk_sel = 3'd7;
        phy_addr = 5'd9;
        reg_addr = 5'd2;
        pulse_read();
        repeat (300) @(negedge clk);
        cfg_soft_rst = 1'b1;
        @(negedge clk);
        cfg_soft_rst = 1'b0;
        chk("R10 soft reset busy", {31'd0, stat_busy}, 0);
        chk("R10 soft reset mdc/oe", {30'd0, mdc, mdio_oe}, 0);
        chk("R10 soft reset not_valid", {31'd0, stat_not_valid}, 1);
        chk("R10 soft reset data", {16'd0, rd_data}, 0);
        cfg_clk_sel = 3'd1;
        f0 = frames;
        pulse_read();
        wait_idle(bc);
        chk("R10 read after soft reset", {16'd0, rd_data}, {16'd0, 5'd9, 5'd2, 6'(f0)});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule